// File: doc/BRIEF.md
# Line-Aligned Range Splitter

This block turns one cache maintenance request, given as a start address and an end address, into a stream of commands for a maintenance engine. It widens the range to whole cache lines. It then cuts the widened range into chunks of bounded size, in increasing address order. Each chunk leaves on a valid/ready command port as an address and a byte count. A sync command always closes the sequence.

A range whose length is within one line of the full address space stands for a wrapped request. Such a range is not split. It is replaced by a single whole-cache command, which is followed by the sync. The largest chunk allowed is the configured maximum less one line. The configured maximum and the line size are power-of-two parameters. Any caller that handles an older engine, one that accepts at most 4 MiB per range operation, sets the maximum to 1<<22.

The block accepts a request only while it is idle. It pulses `done` once the sync has been taken.

Top module: `range_chunker`

## Requirements
- R1: The first range command carries the start address with its low log2(LINE_BYTES) bits cleared. Every range command address is line aligned.
- R2: The byte length is end minus the aligned start, modulo 2^AW. It is rounded up to a multiple of LINE_BYTES, so partial lines at either end are covered.
- R3: Range commands (cmd_kind 0) appear in increasing address order. Each one starts where the previous one ended, and each has size min(remaining, limit). Together they cover exactly the rounded length.
- R4: The chunk limit is MAX_BYTES minus LINE_BYTES. No range command is larger than this limit, and none has size zero.
- R5: A request is treated as a whole-cache operation when its length, computed before rounding, is at least 2^AW minus LINE_BYTES. Such a request produces exactly one whole-cache command (cmd_kind 1, address 0, size 0) and no range commands.
- R6: A sync command (cmd_kind 2, address 0, size 0) follows the last range command, and it also follows the whole-cache command. No command follows the sync.
- R7: A request whose rounded length is zero produces only the sync command.
- R8: req_ready is 1 exactly when the block is idle. A request presented while the block is busy is ignored. done is high for one cycle, in the cycle after the sync is accepted.
- R9: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and cmd_kind, cmd_addr and cmd_size hold their values.
- R10: After reset, req_ready is 1, cmd_valid is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on valid |
| req_start | input | AW | First byte address of range |
| req_end | input | AW | End address (exclusive) of range |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Engine takes command |
| cmd_kind | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_addr | output | AW | Chunk start address (0 unless range) |
| cmd_size | output | AW | Chunk byte count (0 unless range) |
| done | output | 1 | One-cycle pulse after sync accepted |

## Verification
The tests apply several kinds of range. One range is already aligned and fits in a single chunk. One is unaligned at both ends, which separates rounding down of the start from rounding up of the length. One is long and splits into several chunks, with a short remainder at the end. Three ranges sit right at the wrap threshold: two lengths on or above it, which must give the whole-cache form, and one a single byte below it, which must give the longest chunk sequence the block can produce.

A zero-length range shows that the sync is issued even when there are no chunks. A back-pressured run shows that a stalled command holds its fields. A run with a second request held on the input while the block is busy shows that the second request does not disturb the command stream.

// File: rtl/range_chunker.sv
module range_chunker #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 1 << 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_size,
  output logic          done
);
  localparam logic [AW-1:0] LMASK   = ~AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] LIMIT   = AW'(MAX_BYTES - LINE_BYTES);
  localparam logic [AW-1:0] ALL_THR = AW'(0) - AW'(LINE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RANGE, S_ALL, S_SYNC} state_t;

  state_t        state;
  logic [AW-1:0] cur, rem;
  logic [AW-1:0] a_start, raw_len, up_len, chunk;
  logic          fire;

  assign a_start = req_start & LMASK;
  assign raw_len = req_end - a_start;
  assign up_len  = (raw_len + AW'(LINE_BYTES - 1)) & LMASK;
  assign chunk   = (rem < LIMIT) ? rem : LIMIT;

  assign req_ready = (state == S_IDLE);
  assign cmd_valid = (state != S_IDLE);
  assign fire      = cmd_valid && cmd_ready;
  assign cmd_kind  = (state == S_ALL) ? 2'd1 : (state == S_SYNC) ? 2'd2 : 2'd0;
  assign cmd_addr  = (state == S_RANGE) ? cur : '0;
  assign cmd_size  = (state == S_RANGE) ? chunk : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      rem   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid) begin
            cur <= a_start;
            rem <= up_len;
            if (raw_len >= ALL_THR) state <= S_ALL;
            else if (up_len == '0)  state <= S_SYNC;
            else                    state <= S_RANGE;
          end
        S_RANGE:
          if (fire) begin
            cur <= cur + chunk;
            rem <= rem - chunk;
            if (rem == chunk) state <= S_SYNC;
          end
        S_ALL:
          if (fire) state <= S_SYNC;
        default:
          if (fire) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
      endcase
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_size));

  p_chunk_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd0 |-> cmd_size <= LIMIT && cmd_size != '0);

  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd0 |-> (cmd_addr & ~LMASK) == '0 && (cmd_size & ~LMASK) == '0);

  p_all_then_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_kind == 2'd1 |=> cmd_valid && cmd_kind == 2'd2);

  p_done_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_kind == 2'd2 |=> done && req_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/range_chunker_bench.sv
module range_chunker_bench;
  localparam int AW = 16, LINE = 16, MAXB = 64;
  localparam logic [15:0] LIM = 16'(MAXB - LINE);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cmd_ready = 0;
  logic [15:0] req_start = 0, req_end = 0;
  logic req_ready, cmd_valid, done;
  logic [1:0] cmd_kind;
  logic [15:0] cmd_addr, cmd_size;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  range_chunker #(.AW(AW), .LINE_BYTES(LINE), .MAX_BYTES(MAXB)) u_range_chunker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_size(cmd_size), .done(done));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [15:0] st, input logic [15:0] en,
                          input bit stall, input bit hold);
    logic [1:0] ek[$];
    logic [15:0] ea[$], es[$];
    logic [15:0] a, len, c;
    logic [1:0] sk;
    logic [15:0] sa, ss;
    bit prev_stall = 0;
    int idx = 0, k = 0;
    a = st & ~16'(LINE - 1);
    len = en - a;
    if (len >= 16'(16'h0 - 16'(LINE))) begin
      ek.push_back(2'd1); ea.push_back(0); es.push_back(0);
    end else begin
      len = (len + 16'(LINE - 1)) & ~16'(LINE - 1);
      while (len != 0) begin
        c = (len < LIM) ? len : LIM;
        ek.push_back(2'd0); ea.push_back(a); es.push_back(c);
        a += c; len -= c;
      end
    end
    ek.push_back(2'd2); ea.push_back(0); es.push_back(0);

    @(negedge clk);
    chk(req_ready == 1'b1, "R8", {tag, " idle ready"}, int'(req_ready), 1);
    req_valid = 1; req_start = st; req_end = en;
    @(negedge clk);
    if (hold) begin
      req_start = st ^ 16'h0a30; req_end = en ^ 16'h5000;
    end else req_valid = 0;

    while (idx < ek.size() && k < 20000) begin
      cmd_ready = stall ? (k % 3 == 2) : 1'b1;
      if (hold) chk(req_ready == 1'b0, "R8", {tag, " busy ready"}, int'(req_ready), 0);
      if (prev_stall)
        chk(cmd_kind == sk && cmd_addr == sa && cmd_size == ss, "R9",
            {tag, " stalled hold"}, int'(cmd_addr), int'(sa));
      chk(cmd_valid == 1'b1, "R6", {tag, " valid"}, int'(cmd_valid), 1);
      chk(cmd_kind == ek[idx], ek[idx] == 2'd0 ? "R3" : ek[idx] == 2'd1 ? "R5" : "R6",
          {tag, " kind"}, int'(cmd_kind), int'(ek[idx]));
      chk(cmd_addr == ea[idx], ek[idx] == 2'd0 && idx == 0 ? "R1" : "R3",
          {tag, " addr"}, int'(cmd_addr), int'(ea[idx]));
      chk(cmd_size == es[idx], ek[idx] == 2'd0 ? "R4" : "R5",
          {tag, " size"}, int'(cmd_size), int'(es[idx]));
      if (cmd_ready) begin
        idx++; prev_stall = 0;
      end else begin
        prev_stall = 1; sk = cmd_kind; sa = cmd_addr; ss = cmd_size;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 0; cmd_ready = 0;
    chk(done == 1'b1, "R8", {tag, " done pulse"}, int'(done), 1);
    chk(cmd_valid == 1'b0, "R6", {tag, " nothing after sync"}, int'(cmd_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", {tag, " done one cycle"}, int'(done), 0);
    chk(cmd_valid == 1'b0, "R8", {tag, " busy request ignored"}, int'(cmd_valid), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R10", "reset cmd_valid", int'(cmd_valid), 0);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6: run did not complete, actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_case("aligned R1", 16'h0100, 16'h0120, 0, 0);
    run_case("unaligned R2", 16'h0105, 16'h012b, 0, 0);
    run_case("multi R3", 16'h0200, 16'h0300, 1, 0);
    run_case("wrap R5", 16'h1000, 16'h0ff5, 0, 0);
    run_case("threshold R5", 16'h1000, 16'h0ff0, 1, 0);
    run_case("below threshold R4", 16'h1000, 16'h0fef, 0, 0);
    run_case("zero R7", 16'h030a, 16'h0300, 0, 0);
    run_case("busy R8", 16'h0403, 16'h04a1, 1, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule